// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block is the software-visible register file of an interrupt routing controller with a configurable number of request pins (24 by default). Software reaches every register through two bus offsets. A byte-wide selector register at offset 0x00 chooses one internal 32-bit register. A data window at offset 0x10 reads or writes the register the selector has chosen. The internal registers are a 4-bit controller identifier, a read-only version word, and a routing table that holds one 64-bit entry per pin. Each entry is reached as two 32-bit halves, chosen by the low bit of the selector.

The routing table is driven out in full on a flat vector for the servicing logic. Every accepted table write produces a one-cycle notice that carries the entry number. A second one-cycle notice marks a write that changed the entry's mask bit. The servicing logic reports that a level-triggered request is in flight by pulsing a per-pin input, which sets the entry's remote-in-flight flag. Software cannot set that flag. It can only clear it, and it does so by writing the entry's low half.

Bus reads are combinational: `bus_rdata` reflects `bus_addr` and the current state in the same cycle. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x00 loads bits 7:0 of the write data into the selector; a read of offset 0x00 returns the selector zero-extended to 32 bits. The selector changes on no other access.
- R2: With selector 0x01 the window reads (NUM_PINS-1) in bits 23:16, VERSION_CODE in bits 7:0 and zero elsewhere; window writes with this selector change no state.
- R3: With selector 0x00 a window write stores data bits 27:24 as the controller ID, and a window read returns the ID in bits 27:24 with zero elsewhere; selector 0x02 reads the same value, and window writes through it change nothing.
- R4: For a selector S of 0x10 or above, the entry number is (S-0x10)>>1; an odd S reaches entry bits 63:32 and an even S reaches bits 31:0, for both reads and writes.
- R5: Selectors 0x03 to 0x0F, and selectors whose entry number is NUM_PINS or more, read all ones in the window; window writes through them change no state and produce no update notice.
- R6: Entry bit 14 is the remote-in-flight flag. A pulse on `rirr_set[i]` sets it in entry i. A low-half write clears it whatever the data holds, and this clear takes priority over a pulse in the same cycle. A high-half write leaves it unchanged.
- R7: After reset the selector and the ID are zero, and every entry holds 64'h0000_0000_0001_0000, which is mask bit 16 set and every other bit clear.
- R8: A read of any offset other than 0x00 and 0x10 returns zero; a write to such an offset changes no state.
- R9: Each accepted entry write raises `upd_o` for exactly the following cycle, with `upd_idx_o` equal to the entry number.
- R10: `mask_chg_o` is high in the same cycle as `upd_o` when, and only when, that write changed bit 16 of the entry (only a low-half write can do this).
- R11: `tbl_o[64*i+63:64*i]` always equals entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| rirr_set | input | NUM_PINS | Per-pin set pulse for the remote-in-flight flag |
| tbl_o | output | 64*NUM_PINS | Whole routing table, entry i at bits 64*i+63:64*i |
| upd_o | output | 1 | One-cycle notice of an entry write |
| upd_idx_o | output | $clog2(NUM_PINS) | Entry number that goes with upd_o |
| mask_chg_o | output | 1 | One-cycle notice that the write changed the mask bit |

## Verification
The window is exercised with random selector values that run past the last entry and into the gap at 0x03 to 0x0F. These are mixed with random data written to both halves. This separates a correct index and half mapping from off-by-one or swapped-half errors, and it separates valid entries from out-of-range ones. Directed sequences set the remote-in-flight flag and then write the high half and the low half with bit 14 high, which shows whether the flag is protected and whether the clear rule works. Repeated low-half writes that keep the mask and then flip it show whether the mask notice follows actual changes or merely follows writes. Reads and writes at unused offsets, and writes to the version and arbitration selectors, confirm that state stays unchanged.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENTRY_W = 64;
  localparam int HALF_W  = 32;
  localparam int SEL_W   = 8;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  localparam logic [SEL_W-1:0] SEL_ID       = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER      = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB      = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL_BASE = 8'h10;

  localparam int BIT_RIRR = 14;
  localparam int BIT_MASK = 16;
  localparam int ID_LSB   = 24;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << BIT_MASK;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_ENTRY,
    K_NONE
  } win_kind_e;

  typedef struct packed {
    win_kind_e        kind;
    logic             hi;
    logic [SEL_W-1:0] idx;
  } win_dec_t;

  // Entry number reached by a table selector.
  function automatic logic [SEL_W-1:0] entry_index(input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] off;
    off = sel - SEL_TBL_BASE;
    return off >> 1;
  endfunction

  // Read value of the version register.
  function automatic logic [HALF_W-1:0] version_word(input int num_pins,
                                                     input logic [7:0] code);
    logic [7:0] top;
    top = 8'(num_pins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [SEL_W-1:0] sel,
  output win_dec_t         dec
);

  logic [SEL_W-1:0] idx;
  logic             in_tbl;

  always_comb begin
    idx    = entry_index(sel);
    in_tbl = (sel >= SEL_TBL_BASE) && (int'(idx) < NUM_PINS);
    dec.idx = idx;
    dec.hi  = sel[0];
    if (sel == SEL_ID)       dec.kind = K_ID;
    else if (sel == SEL_VER) dec.kind = K_VER;
    else if (sel == SEL_ARB) dec.kind = K_ARB;
    else if (in_tbl)         dec.kind = K_ENTRY;
    else                     dec.kind = K_NONE;
  end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [HALF_W-1:0]  wdata,
  input  logic               rirr_set,
  output logic [ENTRY_W-1:0] q,
  output logic               mask_flip
);

  logic [ENTRY_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (rirr_set) nxt[BIT_RIRR] = 1'b1;
    if (wr_hi) nxt[ENTRY_W-1:HALF_W] = wdata;
    if (wr_lo) begin
      nxt[HALF_W-1:0] = wdata;
      nxt[BIT_RIRR]   = 1'b0;
    end
  end

  assign mask_flip = wr_lo && (wdata[BIT_MASK] != q[BIT_MASK]);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= ENTRY_RST;
    else        q <= nxt;
  end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int        IDX_W        = $clog2(NUM_PINS),
  localparam int        TBL_W        = NUM_PINS * ENTRY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_PINS-1:0] rirr_set,
  output logic [TBL_W-1:0]  tbl_o,
  output logic              upd_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic              mask_chg_o
);

  localparam int ID_W = 4;

  logic [SEL_W-1:0]   sel_q;
  logic [ID_W-1:0]    id_q;
  win_dec_t           dec;
  logic               sel_wr;
  logic               win_wr;
  logic               entry_wr;
  logic               mask_flip_any;
  logic [IDX_W-1:0]   ent_idx;
  logic [NUM_PINS-1:0] mask_flip_vec;
  logic [ENTRY_W-1:0] ent [NUM_PINS];
  logic [ENTRY_W-1:0] ent_rd;
  logic [HALF_W-1:0]  win_rd;

  irq_sel_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .sel (sel_q),
    .dec (dec)
  );

  assign sel_wr        = bus_wr && (bus_addr == OFF_SEL);
  assign win_wr        = bus_wr && (bus_addr == OFF_WIN);
  assign entry_wr      = win_wr && (dec.kind == K_ENTRY);
  assign ent_idx       = dec.idx[IDX_W-1:0];
  assign mask_flip_any = |mask_flip_vec;

  // Selector and identifier registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[SEL_W-1:0];
      if (win_wr && dec.kind == K_ID) id_q <= bus_wdata[ID_LSB +: ID_W];
    end
  end

  // Routing table, one register pair per pin.
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic hit;
    assign hit = entry_wr && (int'(ent_idx) == g);
    irq_route_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (hit && !dec.hi),
      .wr_hi     (hit && dec.hi),
      .wdata     (bus_wdata),
      .rirr_set  (rirr_set[g]),
      .q         (ent[g]),
      .mask_flip (mask_flip_vec[g])
    );
    assign tbl_o[g*ENTRY_W +: ENTRY_W] = ent[g];
  end

  // Update notices to the servicing logic.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_o      <= 1'b0;
      upd_idx_o  <= '0;
      mask_chg_o <= 1'b0;
    end else begin
      upd_o      <= entry_wr;
      mask_chg_o <= entry_wr && mask_flip_any;
      if (entry_wr) upd_idx_o <= ent_idx;
    end
  end

  // Window read path.
  always_comb begin
    ent_rd = '0;
    if (int'(ent_idx) < NUM_PINS) ent_rd = ent[ent_idx];
    case (dec.kind)
      K_ID, K_ARB: win_rd = HALF_W'(id_q) << ID_LSB;
      K_VER:       win_rd = version_word(NUM_PINS, VERSION_CODE);
      K_ENTRY:     win_rd = dec.hi ? ent_rd[ENTRY_W-1:HALF_W] : ent_rd[HALF_W-1:0];
      default:     win_rd = '1;
    endcase
  end

  always_comb begin
    case (bus_addr)
      OFF_SEL: bus_rdata = {{(HALF_W-SEL_W){1'b0}}, sel_q};
      OFF_WIN: bus_rdata = win_rd;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int  NUM_PINS = 24,
  localparam int IDX_W    = $clog2(NUM_PINS),
  localparam int TBL_W    = NUM_PINS * ENTRY_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [SEL_W-1:0] sel_q,
  input logic [3:0]       id_q,
  input logic             entry_wr,
  input logic [TBL_W-1:0] tbl_o,
  input logic             upd_o,
  input logic [IDX_W-1:0] upd_idx_o,
  input logic             mask_chg_o
);

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_SEL) |=> $stable(sel_q));

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_WIN) |=> $stable(id_q));

  // R9
  upd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_wr |=> upd_o);

  // R9
  upd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (int'(upd_idx_o) < NUM_PINS));

  // R10
  mchg_in_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_o |-> upd_o);

  // R6
  rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !$past(sel_q[0])) |-> !tbl_o[{upd_idx_o, 6'd14}]);

endmodule

bind irq_route_regs irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .sel_q      (sel_q),
  .id_q       (id_q),
  .entry_wr   (entry_wr),
  .tbl_o      (tbl_o),
  .upd_o      (upd_o),
  .upd_idx_o  (upd_idx_o),
  .mask_chg_o (mask_chg_o)
);

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb;

  localparam int         NP  = 24;
  localparam logic [7:0] VER = 8'h11;
  localparam int         IW  = $clog2(NP);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [7:0]       bus_addr = 8'h00;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NP-1:0]    rirr_set = '0;
  logic [NP*64-1:0] tbl_o;
  logic             upd_o;
  logic [IW-1:0]    upd_idx_o;
  logic             mask_chg_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_tbl [NP];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;

  always #5 clk = ~clk;

  irq_route_regs #(.NUM_PINS(NP), .VERSION_CODE(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rirr_set(rirr_set),
    .tbl_o(tbl_o), .upd_o(upd_o), .upd_idx_o(upd_idx_o), .mask_chg_o(mask_chg_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Entry number for a selector, or -1 when it reaches no entry.
  function automatic int m_entry(input logic [7:0] s);
    if (s < 8'd16) return -1;
    if (int'(s) / 2 - 8 >= NP) return -1;
    return int'(s) / 2 - 8;
  endfunction

  function automatic logic [31:0] m_win(input logic [7:0] s);
    int e;
    if (s == 8'd0 || s == 8'd2) return {4'h0, m_id, 24'h0};
    if (s == 8'd1) return {8'h00, 8'(NP - 1), 8'h00, VER};
    e = m_entry(s);
    if (e < 0) return 32'hFFFF_FFFF;
    if (s % 2 == 1) return m_tbl[e][63:32];
    return m_tbl[e][31:0];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    int   e;
    logic exp_upd, exp_mchg;
    exp_upd = 1'b0;
    exp_mchg = 1'b0;
    e = -1;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'd0) m_id = d[27:24];
      e = m_entry(m_sel);
      if (e >= 0) begin
        exp_upd = 1'b1;
        if (m_sel % 2 == 1) m_tbl[e][63:32] = d;
        else begin
          exp_mchg = (m_tbl[e][16] != d[16]);
          m_tbl[e][31:0] = d;
          m_tbl[e][14] = 1'b0;
        end
      end
    end
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check({req, " R9 upd"}, {63'b0, upd_o}, {63'b0, exp_upd});
    if (exp_upd) check({req, " R9 idx"}, 64'(upd_idx_o), 64'(e));
    check({req, " R10 mask notice"}, {63'b0, mask_chg_o}, {63'b0, exp_mchg});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic pulse_rirr(input int i);
    @(negedge clk);
    rirr_set = NP'(1) << i;
    @(negedge clk);
    rirr_set = '0;
    m_tbl[i][14] = 1'b1;
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < NP; i++)
      check(req, tbl_o[i*64 +: 64], m_tbl[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
    m_sel = 8'h00;
    m_id = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    rd(8'h00, 32'h0, "R7 selector after reset");
    rd(8'h10, 32'h0, "R7 ID after reset");
    check_table("R7 R11 table after reset");
    check("R7 no notice after reset", {62'b0, upd_o, mask_chg_o}, 64'h0);

    // R1 selector keeps low byte
    wr(8'h00, 32'hABCD_EF01, "R1");
    rd(8'h00, 32'h0000_0001, "R1 selector low byte");
    // R2 version word, writes ignored
    rd(8'h10, 32'h0017_0011, "R2 version read");
    wr(8'h10, 32'hFFFF_FFFF, "R2 write");
    rd(8'h10, 32'h0017_0011, "R2 version after write");
    // R3 ID and arbitration id
    wr(8'h00, 32'h0, "R3 sel");
    wr(8'h10, 32'hF5FF_FFFF, "R3 id write");
    rd(8'h10, 32'h0500_0000, "R3 id read");
    wr(8'h00, 32'h2, "R3 sel arb");
    rd(8'h10, 32'h0500_0000, "R3 arb read");
    wr(8'h10, 32'h0A00_0000, "R3 arb write");
    rd(8'h10, 32'h0500_0000, "R3 arb write ignored");
    // R4 entry halves
    wr(8'h00, 32'h13, "R4 sel");
    wr(8'h10, 32'hDEAD_BEEF, "R4 high write");
    wr(8'h00, 32'h12, "R4 sel");
    rd(8'h10, 32'h0001_0000, "R4 low half untouched");
    wr(8'h00, 32'h13, "R4 sel");
    rd(8'h10, 32'hDEAD_BEEF, "R4 high read entry 1");
    // R5 out-of-range selectors
    wr(8'h00, 32'h40, "R5 sel");
    rd(8'h10, 32'hFFFF_FFFF, "R5 past last entry");
    wr(8'h10, 32'h1234_5678, "R5 write ignored");
    wr(8'h00, 32'h07, "R5 sel gap");
    rd(8'h10, 32'hFFFF_FFFF, "R5 gap selector");
    wr(8'h00, 32'h3F, "R5 last valid");
    rd(8'h10, 32'h0000_0000, "R5 last entry high");
    check_table("R5 R11 table unchanged");
    // R6 remote flag
    pulse_rirr(3);
    wr(8'h00, 32'h16, "R6 sel");
    rd(8'h10, 32'h0001_4000, "R6 flag set by pin");
    wr(8'h00, 32'h17, "R6 sel");
    wr(8'h10, 32'h0102_0304, "R6 high write");
    wr(8'h00, 32'h16, "R6 sel");
    rd(8'h10, 32'h0001_4000, "R6 flag kept by high write");
    wr(8'h10, 32'h0001_4055, "R6 low write clears");
    rd(8'h10, 32'h0001_0055, "R6 flag cleared");
    // R10 mask notice only on change
    wr(8'h10, 32'h0001_0066, "R10 same mask");
    wr(8'h10, 32'h0000_0066, "R10 mask cleared");
    wr(8'h10, 32'h0001_0066, "R10 mask set");
    // R8 other offsets
    rd(8'h20, 32'h0, "R8 unused offset read");
    rd(8'h04, 32'h0, "R8 unused offset read 2");
    wr(8'h20, 32'hFFFF_FFFF, "R8 unused write");
    rd(8'h00, 32'h16, "R8 selector untouched");
    check_table("R8 R11 table untouched");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 8);
      case (r)
        0: wr(8'h00, 32'($urandom_range(0, 71)), "R1 R4 rnd sel");
        1, 2: wr(8'h10, $urandom, "R4 R5 rnd win write");
        3, 4: rd(8'h10, m_win(m_sel), "R4 R5 rnd win read");
        5: rd(8'h00, {24'h0, m_sel}, "R1 rnd sel read");
        6: pulse_rirr(int'($urandom % NP));
        default: check_table("R11 rnd table");
      endcase
    end
    check_table("R11 final table");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule